// File: doc/BRIEF.md
# Microcode Next-PC Sequencer

This block keeps the program counter of a microengine whose control words are 64 bits wide, and on every clock it picks the address of the next control word. Four sources can supply that address: the jump field of the current word, the low bits of the ALU output register, a return address handed over by the call hardware, or the current PC plus one. The jump field is read in one of three ways. In the address category it is a full-width jump. In every other category it is either a jump within the current 4K cluster or a subroutine entry in cluster zero.

Conditional branching is split across two control words. Each word carries a 3-bit condition code, and the block latches it. That latched code then decides whether the following word's selected target is taken. If the condition is false, the sequencer falls through to PC+1. The condition is tested against the carry and zero flags and an indirect-jump control bit, all sampled as the following word executes. Instruction fetch and call-frame management sit outside the block. It consumes already-decoded fields and delivers a registered PC.

Top module: `nxt_pc_seq`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and sets the latched condition to "always", so the first word after reset takes its selected target whatever the flags are.
- R2: Next-PC select 3 loads PC+1, modulo 2^23. A PC of 0x7FFFFF steps to 0.
- R3: Next-PC select 1 loads the low 23 bits of the ALU output register.
- R4: Next-PC select 2 loads the return PC. This select is legal only when the call operation is 7 (return).
- R5: Next-PC select 0 in category 3 (address category) loads the 23-bit jump field, bits 22..0, as the new PC.
- R6: Next-PC select 0 in any category other than 3 produces a cluster jump when the call operation is not 4, 5 or 6. The new PC keeps PC bits 22..12 and takes field bits 11..0.
- R7: Next-PC select 0 in any category other than 3, with call operation 4, 5 or 6, produces a cluster-zero subroutine target. The new PC has field bits 11..4 in bits 11..4, and zeros in bits 22..12 and 3..0.
- R8: The condition codes are: 0 the indirect-jump bit, 1 always, 2 carry, 3 not carry, 4 zero, 5 not zero, 6 carry or zero, 7 neither carry nor zero.
- R9: The condition code given with one word is latched and governs the next word. When it evaluates false, the PC becomes PC+1 instead of the selected target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_sel | input | 2 | Next-PC source select |
| icat | input | 3 | Instruction category |
| call_op | input | 3 | Call-hardware operation code |
| jmp_fld | input | 23 | Jump address field, bits 22..0 |
| cond_code | input | 3 | Condition code, applies to the next word |
| carry | input | 1 | Carry flag |
| zero | input | 1 | Zero flag |
| jindir | input | 1 | Indirect-jump control bit |
| alu_out | input | 32 | ALU output register |
| ret_pc | input | 23 | Return PC from call hardware |
| pc | output | 23 | Registered program counter |

## Verification
Directed words come first:
- Each select is driven with an always-true condition, which isolates the source multiplexer.
- A PC of 0x7FFFFF followed by an increment exposes any failure to wrap.
- Cluster jumps from a PC with nonzero upper bits separate "keep the upper bits" from zero-extension.
- The same field driven with and without a call operation tells the subroutine form apart from the cluster form.

Each of the eight condition codes is then tried with flag values that make it both true and false, which shows whether the decision uses the previous word's code or the current one's. A long run of random words follows, compared against a behavioural model on every clock. Return selects in that run are always paired with the return call operation.

// File: rtl/nxt_seq_pkg.sv
package nxt_seq_pkg;

  typedef enum logic [1:0] {
    SEL_FIELD = 2'd0,
    SEL_ALU   = 2'd1,
    SEL_RET   = 2'd2,
    SEL_INC   = 2'd3
  } nxt_sel_e;

  typedef enum logic [2:0] {
    CND_INDIR  = 3'd0,
    CND_ALWAYS = 3'd1,
    CND_C      = 3'd2,
    CND_NC     = 3'd3,
    CND_Z      = 3'd4,
    CND_NZ     = 3'd5,
    CND_CZ     = 3'd6,
    CND_NCZ    = 3'd7
  } cond_e;

  localparam logic [2:0] CAT_ADDR   = 3'd3;
  localparam logic [2:0] CH_CALL    = 3'd4;
  localparam logic [2:0] CH_OPNCALL = 3'd5;
  localparam logic [2:0] CH_TCALL   = 3'd6;
  localparam logic [2:0] CH_RETURN  = 3'd7;

  function automatic logic is_call(input logic [2:0] op);
    return (op == CH_CALL) || (op == CH_OPNCALL) || (op == CH_TCALL);
  endfunction

endpackage

// File: rtl/nxt_cond_eval.sv
module nxt_cond_eval
  import nxt_seq_pkg::*;
(
  input  logic [2:0] code,
  input  logic       carry,
  input  logic       zero,
  input  logic       jindir,
  output logic       ok
);
  always_comb begin
    unique case (code)
      CND_INDIR:  ok = jindir;
      CND_ALWAYS: ok = 1'b1;
      CND_C:      ok = carry;
      CND_NC:     ok = ~carry;
      CND_Z:      ok = zero;
      CND_NZ:     ok = ~zero;
      CND_CZ:     ok = carry | zero;
      default:    ok = ~(carry | zero);
    endcase
  end
endmodule

// File: rtl/nxt_target_mux.sv
module nxt_target_mux
  import nxt_seq_pkg::*;
#(
  parameter int PC_W      = 23,
  parameter int DATA_W    = 32,
  parameter int CLUSTER_W = 12,
  parameter int SUB_LO    = 4
) (
  input  logic [1:0]      sel,
  input  logic [2:0]      icat,
  input  logic [2:0]      call_op,
  input  logic [PC_W-1:0] jmp_fld,
  input  logic [DATA_W-1:0] alu_out,
  input  logic [PC_W-1:0] ret_pc,
  input  logic [PC_W-1:0] pc,
  input  logic            take,
  output logic [PC_W-1:0] next_pc
);
  localparam int HI_W = PC_W - CLUSTER_W;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] fld_tgt;
  logic [PC_W-1:0] clus_tgt;
  logic [PC_W-1:0] sub_tgt;
  logic [PC_W-1:0] sel_tgt;

  assign pc_inc   = pc + PC_W'(1);
  assign clus_tgt = {pc[PC_W-1:CLUSTER_W], jmp_fld[CLUSTER_W-1:0]};
  assign sub_tgt  = {{HI_W{1'b0}}, jmp_fld[CLUSTER_W-1:SUB_LO], {SUB_LO{1'b0}}};

  always_comb begin
    if (icat == CAT_ADDR)      fld_tgt = jmp_fld;
    else if (is_call(call_op)) fld_tgt = sub_tgt;
    else                       fld_tgt = clus_tgt;
  end

  always_comb begin
    unique case (sel)
      SEL_FIELD: sel_tgt = fld_tgt;
      SEL_ALU:   sel_tgt = alu_out[PC_W-1:0];
      SEL_RET:   sel_tgt = ret_pc;
      default:   sel_tgt = pc_inc;
    endcase
  end

  assign next_pc = take ? sel_tgt : pc_inc;
endmodule

// File: rtl/nxt_pc_seq.sv
module nxt_pc_seq
  import nxt_seq_pkg::*;
#(
  parameter int PC_W      = 23,
  parameter int DATA_W    = 32,
  parameter int CLUSTER_W = 12,
  parameter int SUB_LO    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        nxt_sel,
  input  logic [2:0]        icat,
  input  logic [2:0]        call_op,
  input  logic [PC_W-1:0]   jmp_fld,
  input  logic [2:0]        cond_code,
  input  logic              carry,
  input  logic              zero,
  input  logic              jindir,
  input  logic [DATA_W-1:0] alu_out,
  input  logic [PC_W-1:0]   ret_pc,
  output logic [PC_W-1:0]   pc
);
  logic [2:0]      cond_q;
  logic            take;
  logic [PC_W-1:0] next_pc;

  nxt_cond_eval u_cond (
    .code   (cond_q),
    .carry  (carry),
    .zero   (zero),
    .jindir (jindir),
    .ok     (take)
  );

  nxt_target_mux #(
    .PC_W      (PC_W),
    .DATA_W    (DATA_W),
    .CLUSTER_W (CLUSTER_W),
    .SUB_LO    (SUB_LO)
  ) u_mux (
    .sel     (nxt_sel),
    .icat    (icat),
    .call_op (call_op),
    .jmp_fld (jmp_fld),
    .alu_out (alu_out),
    .ret_pc  (ret_pc),
    .pc      (pc),
    .take    (take),
    .next_pc (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      cond_q <= CND_ALWAYS;
    end else begin
      pc     <= next_pc;
      cond_q <= cond_code;
    end
  end

  // R1
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc == '0);
  p_reset_cond_r1: assert property (@(posedge clk) rst |=> cond_q == CND_ALWAYS);

  // R2
  p_inc_step_r2: assert property (@(posedge clk) disable iff (rst)
    nxt_sel == SEL_INC |=> pc == $past(pc) + PC_W'(1));

  // R4
  p_ret_needs_return_r4: assert property (@(posedge clk) disable iff (rst)
    nxt_sel == SEL_RET |-> call_op == CH_RETURN);

  // R5
  p_long_jump_r5: assert property (@(posedge clk) disable iff (rst)
    (nxt_sel == SEL_FIELD && icat == CAT_ADDR && take) |=> pc == $past(jmp_fld));

  // R6
  p_cluster_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (nxt_sel == SEL_FIELD && icat != CAT_ADDR && !is_call(call_op) && take)
    |=> pc[PC_W-1:CLUSTER_W] == $past(pc[PC_W-1:CLUSTER_W]));

  // R9
  p_false_falls_r9: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc == $past(pc) + PC_W'(1));
endmodule

// File: tb/sim_nxt_pc_seq.sv
module sim_nxt_pc_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  nxt_sel = 2'd3;
  logic [2:0]  icat = 3'd0;
  logic [2:0]  call_op = 3'd0;
  logic [22:0] jmp_fld = '0;
  logic [2:0]  cond_code = 3'd1;
  logic        carry = 1'b0, zero = 1'b0, jindir = 1'b0;
  logic [31:0] alu_out = '0;
  logic [22:0] ret_pc = '0;
  logic [22:0] pc;

  int n_cmp = 0, n_bad = 0;
  logic [22:0] exp_pc;
  int exp_cond;
  bit done = 0;

  always #4 clk = ~clk;

  nxt_pc_seq u0 (
    .clk(clk), .rst(rst), .nxt_sel(nxt_sel), .icat(icat), .call_op(call_op),
    .jmp_fld(jmp_fld), .cond_code(cond_code), .carry(carry), .zero(zero),
    .jindir(jindir), .alu_out(alu_out), .ret_pc(ret_pc), .pc(pc)
  );

  function automatic bit cond_true(int code, bit c, bit z, bit j);
    case (code)
      0: return j;
      1: return 1;
      2: return c;
      3: return !c;
      4: return z;
      5: return !z;
      6: return c || z;
      default: return !(c || z);
    endcase
  endfunction

  task automatic check(string req, logic [22:0] exp);
    n_cmp++;
    if (pc !== exp) begin
      n_bad++;
      $display("FAIL %s: pc actual %h expected %h", req, pc, exp);
    end
  endtask

  // drive one word (inputs already set), model it, compare after the edge
  task automatic step();
    logic [22:0] nxt;
    string req;
    bit ok;
    ok = cond_true(exp_cond, carry, zero, jindir);
    if (!ok) begin
      nxt = exp_pc + 23'd1;
      req = "R9";
    end else begin
      case (nxt_sel)
        2'd3: begin nxt = exp_pc + 23'd1; req = "R2"; end
        2'd1: begin nxt = alu_out[22:0]; req = "R3"; end
        2'd2: begin nxt = ret_pc; req = "R4"; end
        default: begin
          if (icat == 3'd3) begin
            nxt = jmp_fld; req = "R5";
          end else if (call_op >= 3'd4 && call_op <= 3'd6) begin
            nxt = {11'd0, jmp_fld[11:4], 4'd0}; req = "R7";
          end else begin
            nxt = {exp_pc[22:12], jmp_fld[11:0]}; req = "R6";
          end
        end
      endcase
      if (exp_cond != 1) req = {req, "/R8"};
    end
    @(posedge clk);
    @(negedge clk);
    check(req, nxt);
    exp_pc = nxt;
    exp_cond = int'(cond_code);
  endtask

  task automatic word(logic [1:0] s, logic [2:0] cat, logic [2:0] op,
                      logic [22:0] f, logic [2:0] cc);
    nxt_sel = s; icat = cat; call_op = op; jmp_fld = f; cond_code = cc;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 23'd0);
    rst = 1'b0;
    exp_pc = '0;
    exp_cond = 1;
    // R1: flags all false, reset condition must still take the jump
    carry = 0; zero = 0; jindir = 0;
    word(2'd0, 3'd3, 3'd0, 23'h5A_1234, 3'd1);
    // R2 increments
    word(2'd3, 3'd0, 3'd0, 23'h0, 3'd1);
    // R3 ALU register, then wrap R2
    alu_out = 32'hFFFF_FFFF;
    word(2'd1, 3'd0, 3'd0, 23'h0, 3'd1);
    word(2'd3, 3'd0, 3'd0, 23'h0, 3'd1);
    // R4 return
    ret_pc = 23'h3C_0F0F;
    word(2'd2, 3'd0, 3'd7, 23'h0, 3'd1);
    // R6 cluster keeps upper bits
    word(2'd0, 3'd0, 3'd0, 23'h7F_FABC, 3'd1);
    word(2'd0, 3'd4, 3'd1, 23'h00_0123, 3'd1);
    // R7 subroutine form, same field
    word(2'd0, 3'd0, 3'd4, 23'h7F_FABC, 3'd1);
    word(2'd0, 3'd3, 3'd0, 23'h44_4444, 3'd1);
    word(2'd0, 3'd1, 3'd6, 23'h00_0FFF, 3'd1);
    // R8/R9: each code, true then false
    for (int code = 0; code < 8; code++) begin
      for (int t = 0; t < 4; t++) begin
        carry = t[0]; zero = t[1]; jindir = t[0] ^ t[1];
        word(2'd3, 3'd0, 3'd0, 23'h0, 3'(code));
        word(2'd0, 3'd3, 3'd0, 23'(32'h1000 * (t + 1) + code), 3'd1);
      end
    end
    // random words
    for (int i = 0; i < 4000; i++) begin
      carry = 1'($urandom); zero = 1'($urandom); jindir = 1'($urandom);
      alu_out = $urandom; ret_pc = 23'($urandom);
      nxt_sel = 2'($urandom); icat = 3'($urandom); call_op = 3'($urandom);
      if (nxt_sel == 2'd2) call_op = 3'd7;
      jmp_fld = 23'($urandom); cond_code = 3'($urandom);
      step();
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule